// File: doc/BRIEF.md
# Inverting Parity Transceiver with Error Latch

This block sits between two 8-bit buses, called A and B, and passes data across in either direction with every bit inverted. Two active-low output enables choose which side is driven. With only the B enable low, the A bus is copied, inverted, onto the B bus. A parity bit is produced alongside so that the nine driven bits carry an odd number of ones. With only the A enable low, the B bus is copied, inverted, onto the A bus. In that case the eight B bits and the received parity bit are checked for odd parity.

Each port, and the parity line, is modelled as a separate input, output and output-enable triple rather than a tri-state net. A checker failure is sampled into a sticky error register on the rising clock edge. That register drives an active-low, open-drain-style error flag, modelled as a pull-down enable. An asynchronous active-low clear empties the register.

Pulling both enables low sends data from A to B, inverts the generated parity bit on purpose, and presents an error to the register. Diagnostic software can use this mode to prove the flag path end to end.

Top module: `parity_xcvr`

## Requirements
- R1: `a_out_en` is 1 exactly when `a_oe_n` is 0 and `b_oe_n` is 1. The A and B outputs are never enabled together.
- R2: `b_out_en` equals the inverse of `b_oe_n`. While it is 1, `b_out` is the bitwise complement of `a_in`. While it is 0, `b_out` is all zeros.
- R3: While `a_out_en` is 1, `a_out` is the bitwise complement of `b_in`. While it is 0, `a_out` is all zeros.
- R4: `par_out_en` equals the inverse of `b_oe_n`. With `a_oe_n` 1 and `b_oe_n` 0, `par_out` is chosen so that `b_out` and `par_out` together hold an odd number of ones. While `par_out_en` is 0, `par_out` is 0.
- R5: With both enables 0, `par_out` is the inverse of the R4 value, so the nine driven bits hold an even number of ones.
- R6: With `a_oe_n` 0 and `b_oe_n` 1, an even number of ones across `b_in` and `par_in` is an error. The error is captured at the next rising `clk` edge. An odd count presents no error.
- R7: The error register is sticky. Once set, it stays set across later rising edges whatever the inputs, until a clear.
- R8: `err_pull` is 1 exactly when the error register is set. The flag is never actively driven high.
- R9: `clear_n` low empties the register at once, without waiting for a clock edge. It overrides any `clk` edge while it stays low.
- R10: With both enables 0, an error is presented, so the next rising `clk` edge sets `err_pull`.
- R11: With both enables 1, no output enable is active and no error is presented. A clear register stays clear across edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Error register clock, rising edge |
| clear_n | input | 1 | Asynchronous active-low register clear |
| a_oe_n | input | 1 | Active-low enable for A-side drive (B to A) |
| b_oe_n | input | 1 | Active-low enable for B-side drive (A to B) |
| a_in | input | 8 | Value sensed on the A bus |
| a_out | output | 8 | Value driven onto the A bus |
| a_out_en | output | 1 | A bus drive enable |
| b_in | input | 8 | Value sensed on the B bus |
| b_out | output | 8 | Value driven onto the B bus |
| b_out_en | output | 1 | B bus drive enable |
| par_in | input | 1 | Parity bit received with the B bus |
| par_out | output | 1 | Parity bit driven with the B bus |
| par_out_en | output | 1 | Parity line drive enable |
| err_pull | output | 1 | Pull-down enable for the active-low error flag |

## Verification
The hardest condition to reach from the ports is a clear that collides with pending errors. In that case `clear_n` is held low across rising edges while the checker sees bad parity, or while the diagnostic mode presents an error. The register must stay empty throughout and must set on the first edge after release. The stimulus produces this with a directed sequence: bad parity is set up in check mode, the clear is lowered between edges, several edges pass under it, and then it is raised. A long run of random enables, data and clear pulses follows and is compared cycle by cycle with a behavioural model that counts ones instead of reducing with XOR.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  // Direction and diagnostic state decoded from the two enables.
  typedef enum logic [1:0] {
    XMODE_IDLE = 2'd0,   // nothing driven
    XMODE_A2B  = 2'd1,   // A to B with parity generation
    XMODE_B2A  = 2'd2,   // B to A with parity checking
    XMODE_DIAG = 2'd3    // A to B, parity inverted, error forced
  } xmode_t;

  // Bit that completes an odd count of ones, given the XOR of the others.
  function automatic logic odd_fill(input logic xor_sum);
    return ~xor_sum;
  endfunction

  // Nine-bit group is bad when its overall XOR is 0, i.e. an even count.
  function automatic logic group_is_even(input logic xor_sum);
    return ~xor_sum;
  endfunction

endpackage

// File: rtl/xcvr_mode_decode.sv
module xcvr_mode_decode
  import xcvr_pkg::*;
(
  input  logic   a_oe_n,
  input  logic   b_oe_n,
  output xmode_t mode,
  output logic   drive_a,
  output logic   drive_b
);

  always_comb begin
    unique case ({a_oe_n, b_oe_n})
      2'b11:   mode = XMODE_IDLE;
      2'b10:   mode = XMODE_A2B;
      2'b01:   mode = XMODE_B2A;
      default: mode = XMODE_DIAG;
    endcase
  end

  // A side drives only in pure B-to-A mode; B side drives in A2B and DIAG.
  assign drive_a = (mode == XMODE_B2A);
  assign drive_b = (mode == XMODE_A2B) || (mode == XMODE_DIAG);

endmodule

// File: rtl/xcvr_datapath.sv
module xcvr_datapath #(
  parameter int W = 8
) (
  input  logic         drive_a,
  input  logic         drive_b,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] a_out,
  output logic [W-1:0] b_out
);

  // One inverting lane per bit, gated to zero when its side is not driven.
  for (genvar i = 0; i < W; i++) begin : g_lane
    assign b_out[i] = drive_b & ~a_in[i];
    assign a_out[i] = drive_a & ~b_in[i];
  end

endmodule

// File: rtl/xcvr_parity_unit.sv
module xcvr_parity_unit
  import xcvr_pkg::*;
#(
  parameter int W = 8
) (
  input  xmode_t       mode,
  input  logic [W-1:0] b_drv,
  input  logic [W-1:0] b_in,
  input  logic         par_in,
  output logic         par_gen,
  output logic         err_det
);

  logic drv_xor;
  logic rx_xor;
  logic odd_bit;

  assign drv_xor = ^b_drv;
  assign rx_xor  = ^{b_in, par_in};
  assign odd_bit = odd_fill(drv_xor);

  always_comb begin
    par_gen = 1'b0;
    err_det = 1'b0;
    unique case (mode)
      XMODE_A2B:  par_gen = odd_bit;
      XMODE_DIAG: begin
        par_gen = ~odd_bit;
        err_det = 1'b1;
      end
      XMODE_B2A:  err_det = group_is_even(rx_xor);
      default: begin
        par_gen = 1'b0;
        err_det = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/xcvr_err_reg.sv
module xcvr_err_reg (
  input  logic clk,
  input  logic clear_n,
  input  logic err_det,
  output logic err_q
);

  always_ff @(posedge clk or negedge clear_n) begin
    if (!clear_n) err_q <= 1'b0;
    else          err_q <= err_q | err_det;
  end

endmodule

// File: rtl/parity_xcvr.sv
module parity_xcvr
  import xcvr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         clear_n,
  input  logic         a_oe_n,
  input  logic         b_oe_n,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic         a_out_en,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] b_out,
  output logic         b_out_en,
  input  logic         par_in,
  output logic         par_out,
  output logic         par_out_en,
  output logic         err_pull
);

  xmode_t mode;
  logic   drive_a;
  logic   drive_b;
  logic   par_gen;
  logic   err_det;
  logic   err_q;

  xcvr_mode_decode u_dec (
    .a_oe_n  (a_oe_n),
    .b_oe_n  (b_oe_n),
    .mode    (mode),
    .drive_a (drive_a),
    .drive_b (drive_b)
  );

  xcvr_datapath #(.W(W)) u_dp (
    .drive_a (drive_a),
    .drive_b (drive_b),
    .a_in    (a_in),
    .b_in    (b_in),
    .a_out   (a_out),
    .b_out   (b_out)
  );

  xcvr_parity_unit #(.W(W)) u_par (
    .mode    (mode),
    .b_drv   (b_out),
    .b_in    (b_in),
    .par_in  (par_in),
    .par_gen (par_gen),
    .err_det (err_det)
  );

  xcvr_err_reg u_err (
    .clk     (clk),
    .clear_n (clear_n),
    .err_det (err_det),
    .err_q   (err_q)
  );

  assign a_out_en   = drive_a;
  assign b_out_en   = drive_b;
  assign par_out_en = drive_b;
  assign par_out    = par_gen;
  assign err_pull   = err_q;

endmodule

// File: rtl/xcvr_checker.sv
module xcvr_checker #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         clear_n,
  input logic         a_oe_n,
  input logic         b_oe_n,
  input logic [W-1:0] a_in,
  input logic [W-1:0] a_out,
  input logic         a_out_en,
  input logic [W-1:0] b_in,
  input logic [W-1:0] b_out,
  input logic         b_out_en,
  input logic         par_in,
  input logic         par_out,
  input logic         par_out_en,
  input logic         err_pull,
  input logic         err_det
);

  assert_one_side_R1: assert property (@(posedge clk) disable iff (!clear_n)
    !(a_out_en && b_out_en));

  assert_b_inverts_R2: assert property (@(posedge clk) disable iff (!clear_n)
    b_out_en |-> (b_out == ~a_in));

  assert_a_inverts_R3: assert property (@(posedge clk) disable iff (!clear_n)
    a_out_en |-> (a_out == ~b_in));

  assert_gen_odd_R4: assert property (@(posedge clk) disable iff (!clear_n)
    (par_out_en && a_oe_n) |-> ($countones({b_out, par_out}) % 2 == 1));

  assert_diag_even_R5: assert property (@(posedge clk) disable iff (!clear_n)
    (par_out_en && !a_oe_n) |-> ($countones({b_out, par_out}) % 2 == 0));

  assert_check_catch_R6: assert property (@(posedge clk) disable iff (!clear_n)
    (!a_oe_n && b_oe_n && ($countones({b_in, par_in}) % 2 == 0)) |=> err_pull);

  assert_sticky_R7: assert property (@(posedge clk) disable iff (!clear_n)
    err_pull |=> err_pull);

  assert_capture_R8: assert property (@(posedge clk) disable iff (!clear_n)
    err_det |=> err_pull);

  assert_clear_holds_R9: assert property (@(posedge clk)
    !clear_n |-> !err_pull);

  assert_diag_sets_R10: assert property (@(posedge clk) disable iff (!clear_n)
    (!a_oe_n && !b_oe_n) |=> err_pull);

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!clear_n)
    (a_oe_n && !err_pull) |=> !err_pull);

endmodule

bind parity_xcvr xcvr_checker #(.W(W)) u_chk (
  .clk        (clk),
  .clear_n    (clear_n),
  .a_oe_n     (a_oe_n),
  .b_oe_n     (b_oe_n),
  .a_in       (a_in),
  .a_out      (a_out),
  .a_out_en   (a_out_en),
  .b_in       (b_in),
  .b_out      (b_out),
  .b_out_en   (b_out_en),
  .par_in     (par_in),
  .par_out    (par_out),
  .par_out_en (par_out_en),
  .err_pull   (err_pull),
  .err_det    (err_det)
);

// File: tb/sim_parity_xcvr.sv
module sim_parity_xcvr;

  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         clear_n = 1'b0;
  logic         a_oe_n = 1'b1;
  logic         b_oe_n = 1'b1;
  logic [W-1:0] a_in = '0;
  logic [W-1:0] b_in = '0;
  logic         par_in = 1'b0;
  logic [W-1:0] a_out;
  logic [W-1:0] b_out;
  logic         a_out_en;
  logic         b_out_en;
  logic         par_out;
  logic         par_out_en;
  logic         err_pull;

  int checks = 0;
  int errors = 0;
  int m_err  = 0;   // reference model of the error register

  always #(CLK_PERIOD/2) clk = ~clk;

  parity_xcvr #(.W(W)) u0 (
    .clk(clk), .clear_n(clear_n), .a_oe_n(a_oe_n), .b_oe_n(b_oe_n),
    .a_in(a_in), .a_out(a_out), .a_out_en(a_out_en),
    .b_in(b_in), .b_out(b_out), .b_out_en(b_out_en),
    .par_in(par_in), .par_out(par_out), .par_out_en(par_out_en),
    .err_pull(err_pull)
  );

  function automatic int ones(input logic [W-1:0] v);
    int n = 0;
    for (int i = 0; i < W; i++) if (v[i] === 1'b1) n++;
    return n;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
    end
  endtask

  // Drive one cycle between edges, compare, then advance the model at the edge.
  task automatic step(input logic aoe, input logic boe, input logic [W-1:0] a,
                      input logic [W-1:0] b, input logic p, input logic clr);
    int  e_aen, e_ben, e_a, e_b, e_pen, e_p, det, cnt;
    @(negedge clk);
    a_oe_n = aoe; b_oe_n = boe; a_in = a; b_in = b; par_in = p; clear_n = clr;
    if (!clr) m_err = 0;
    #1;
    e_ben = (boe == 1'b0) ? 1 : 0;
    e_aen = (aoe == 1'b0 && boe == 1'b1) ? 1 : 0;
    e_b   = e_ben ? int'(8'hFF - a) : 0;
    e_a   = e_aen ? int'(8'hFF - b) : 0;
    e_pen = e_ben;
    e_p   = 0;
    if (e_ben) begin
      cnt = ones(W'(e_b));
      e_p = (cnt % 2 == 0) ? 1 : 0;
      if (aoe == 1'b0) e_p = 1 - e_p;
    end
    chk("R1 a_out_en", int'(a_out_en), e_aen);
    chk("R3 a_out",    int'(a_out),    e_a);
    chk("R2 b_out_en", int'(b_out_en), e_ben);
    chk("R2 b_out",    int'(b_out),    e_b);
    chk("R4 par_out_en", int'(par_out_en), e_pen);
    chk((aoe == 1'b0) ? "R5 par_out" : "R4 par_out", int'(par_out), e_p);
    chk(clr ? "R8 err_pull" : "R9 err_pull", int'(err_pull), m_err);
    det = 0;
    if (aoe == 1'b0 && boe == 1'b0) det = 1;
    else if (aoe == 1'b0 && ((ones(b) + int'(p)) % 2 == 0)) det = 1;
    @(posedge clk);
    if (clr && det != 0) m_err = 1;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired, actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    // R9 reset state with clear held low
    step(1, 1, 8'h00, 8'h00, 0, 0);
    step(1, 1, 8'h3C, 8'h00, 0, 1);
    // R11 idle: nothing driven, no error captured
    step(1, 1, 8'hFF, 8'h00, 0, 1);
    // R2 R4 generation over several patterns
    step(1, 0, 8'h00, 8'h00, 0, 1);
    step(1, 0, 8'hFF, 8'h00, 0, 1);
    step(1, 0, 8'h01, 8'h00, 0, 1);
    step(1, 0, 8'hA5, 8'h00, 0, 1);
    // R3 R6 good parity in check mode (3 ones + 0 -> odd)
    step(0, 1, 8'h00, 8'h07, 0, 1);
    step(0, 1, 8'h00, 8'h00, 1, 1);
    // R6 bad parity (4 ones) -> error on edge
    step(0, 1, 8'h00, 8'h0F, 0, 1);
    // R7 sticky through good traffic and idle
    step(0, 1, 8'h00, 8'h07, 0, 1);
    step(1, 1, 8'h00, 8'h00, 0, 1);
    // R9 clear held over bad parity edges, then release
    step(0, 1, 8'h00, 8'hFF, 0, 0);
    step(0, 1, 8'h00, 8'hFF, 0, 0);
    step(0, 1, 8'h00, 8'hFF, 0, 1);
    step(1, 1, 8'h00, 8'h00, 0, 0);
    // R5 R10 diagnostic mode
    step(0, 0, 8'h00, 8'h00, 0, 1);
    step(0, 0, 8'h5A, 8'h00, 0, 1);
    step(1, 1, 8'h00, 8'h00, 0, 1);
    // R9 clear under diagnostic mode keeps register empty
    step(0, 0, 8'h12, 8'h00, 0, 0);
    step(1, 1, 8'h00, 8'h00, 0, 1);
    // random traffic against the model
    for (int k = 0; k < 400; k++) begin
      logic [3:0] r;
      r = 4'($urandom);
      step(r[0], r[1], 8'($urandom), 8'($urandom), r[2],
           (r[3] | r[2] | r[1]) ? 1'b1 : 1'b0);
    end
    step(1, 1, 8'h00, 8'h00, 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule